// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is the serial control path of a clock generator. It sits on the two-wire management bus and gives a host access to a small bank of 8-bit control registers. The design oversamples SCL and SDA with the chip's system clock and finds start and stop conditions. It recognises its fixed bus address and moves bytes into or out of the register bank. On SDA it only pulls the line low, through an open-drain enable.

Two access styles are supported, and the command byte selects between them. An indexed access reads or writes one register at an offset carried in the command. A sequential access walks the bank from register 0 upward. A sequential write sends a byte count first, and the slave acknowledges that count but does not use it. A sequential read makes the slave send the number of implemented registers before the data. Either kind of transfer may end after any whole byte. The rest of the chip reads and writes the same registers through a plain parallel port. Every register returns to its default value on reset.

Top module: `smbreg_slave`

## Requirements
- R1: The slave acknowledges only address byte 0xD2 (write) or 0xD3 (read), which is 7-bit address 0x69 with R/W as bit 0. For any other address it sends no acknowledge and ignores the bus until the next start.
- R2: SDA is sampled on rising SCL. The slave raises `sda_oe` (pull SDA low) only while SCL is low. On a start or stop it releases SDA.
- R3: In the command byte, bit 7 = 1 selects an indexed access at offset bits 4:0, and bit 7 = 0 selects a sequential access. Bits 6:5 must be 00; otherwise the command byte is not acknowledged and nothing is written.
- R4: An indexed write (address+W, command, data, stop) stores the data byte at the command offset, and every byte is acknowledged.
- R5: An indexed read (address+W, command, repeated start, address+R) returns the register at the command offset, MSB first. A master NACK ends the transfer.
- R6: A sequential write acknowledges a byte count that it does not store. It then writes the data bytes to registers 0, 1, 2 and so on in order, and a stop may follow any whole byte.
- R7: A sequential read first returns the register count (12 by default). It then returns register 0, 1, 2 and so on for as long as the master acknowledges.
- R8: Offsets at or above the register count accept writes with an acknowledge but store nothing, and reads there return 0x00, on both the bus and the core port.
- R9: After reset each register holds its default: reg0=0x87, reg1=0x3C, reg3=0x63, reg4=0xFF, reg5=0xFF, reg6=0x08, reg7=0x88, reg11=0x21, and all others 0x00.
- R10: A start or stop that arrives part-way through a byte ends the transfer without writing the partial byte, and the slave returns to idle on a stop.
- R11: The core port writes a register on `core_we` and reads any register combinationally. A value written by the core can be read back over the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| core_we | input | 1 | Core-side register write strobe |
| core_waddr | input | 5 | Core-side write offset |
| core_wdata | input | 8 | Core-side write data |
| core_raddr | input | 5 | Core-side read offset |
| core_rdata | output | 8 | Core-side read data, 0x00 beyond the bank |

## Verification
Four properties are checked on every cycle. The SDA pull-down may only begin while SCL is low. The slave never drives SDA while idle. A stop always leaves the slave idle and released. The registers hold their defaults in the first cycle after reset. The bench scenarios cover the protocol-level behaviour, which no single-cycle property can show. These are the choice between indexed and sequential access, the unused byte count, the leading register count in a sequential read, the silence after a wrong address or device-select field, the zero data beyond the bank, and the loss of a byte cut off by a stop.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;

    localparam int OFFS_W = 5;
    localparam logic [6:0] DEV_ADDR = 7'h69;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_COUNT,
        ST_WDATA,
        ST_TX,
        ST_MACK
    } phase_e;

    // Line events as seen in the system clock domain
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } busev_t;

    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h87;
            1:       return 8'h3C;
            3:       return 8'h63;
            4:       return 8'hFF;
            5:       return 8'hFF;
            6:       return 8'h08;
            7:       return 8'h88;
            11:      return 8'h21;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic cmd_indexed(input logic [7:0] c);
        return c[7];
    endfunction

    function automatic logic cmd_select_ok(input logic [7:0] c);
        return c[6:5] == 2'b00;
    endfunction

endpackage

// File: rtl/smbreg_line_sync.sv
module smbreg_line_sync
    import smbreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   scl_i,
    input  logic   sda_i,
    output busev_t ev
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_sh;
    logic [TOP:0] sda_sh;
    logic         scl_d;
    logic         sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[TOP-1:0], scl_i};
            sda_sh <= {sda_sh[TOP-1:0], sda_i};
            scl_d  <= scl_sh[TOP];
            sda_d  <= sda_sh[TOP];
        end
    end

    always_comb begin
        ev.scl      = scl_sh[TOP];
        ev.sda      = sda_sh[TOP];
        ev.scl_rise = scl_sh[TOP] & ~scl_d;
        ev.scl_fall = ~scl_sh[TOP] & scl_d;
        ev.start    = scl_sh[TOP] & scl_d & sda_d & ~sda_sh[TOP];
        ev.stop     = scl_sh[TOP] & scl_d & ~sda_d & sda_sh[TOP];
    end

endmodule

// File: rtl/smbreg_bank.sv
module smbreg_bank
    import smbreg_pkg::*;
#(
    parameter int NREG = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [OFFS_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              core_we,
    input  logic [OFFS_W-1:0] core_waddr,
    input  logic [7:0]        core_wdata,
    input  logic [OFFS_W-1:0] core_raddr,
    output logic [7:0]        core_rdata
);
    logic [7:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // bus write takes priority over a same-cycle core write
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= reg_default(i);
            else if (bus_we && bus_addr == OFFS_W'(i))
                regs[i] <= bus_wdata;
            else if (core_we && core_waddr == OFFS_W'(i))
                regs[i] <= core_wdata;
        end

        AST_RESET_DEFAULT: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> regs[i] == reg_default(i)); // R9
    end

    always_comb begin
        bus_rdata  = 8'h00;
        core_rdata = 8'h00;
        for (int i = 0; i < NREG; i++) begin
            if (bus_addr == OFFS_W'(i))   bus_rdata  = regs[i];
            if (core_raddr == OFFS_W'(i)) core_rdata = regs[i];
        end
    end

endmodule

// File: rtl/smbreg_link_fsm.sv
module smbreg_link_fsm
    import smbreg_pkg::*;
#(
    parameter int NREG = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  busev_t            ev,
    output logic              sda_oe,
    output logic              bus_we,
    output logic [OFFS_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata
);
    phase_e            st;
    phase_e            after_ack;
    logic [3:0]        bitcnt;
    logic [7:0]        sh;
    logic [7:0]        txsh;
    logic              acking;
    logic [OFFS_W-1:0] ptr;
    logic              blk;
    logic              send_cnt;
    logic              mack_ok;
    logic              oe;
    logic              byte_done;
    logic [7:0]        load_byte;

    assign sda_oe    = oe;
    assign bus_addr  = ptr;
    assign bus_wdata = sh;
    assign byte_done = ev.scl_fall && !acking && bitcnt == 4'd8;
    assign bus_we    = (st == ST_WDATA) && byte_done;
    assign load_byte = send_cnt ? 8'(NREG) : bus_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            after_ack <= ST_IDLE;
            bitcnt    <= '0;
            sh        <= '0;
            txsh      <= '0;
            acking    <= 1'b0;
            ptr       <= '0;
            blk       <= 1'b0;
            send_cnt  <= 1'b0;
            mack_ok   <= 1'b0;
            oe        <= 1'b0;
        end else if (ev.start) begin
            st     <= ST_ADDR;
            bitcnt <= '0;
            acking <= 1'b0;
            oe     <= 1'b0;
        end else if (ev.stop) begin
            st     <= ST_IDLE;
            bitcnt <= '0;
            acking <= 1'b0;
            oe     <= 1'b0;
        end else begin
            case (st)
                ST_ADDR, ST_CMD, ST_COUNT, ST_WDATA: begin
                    if (acking) begin
                        if (ev.scl_fall) begin
                            acking <= 1'b0;
                            bitcnt <= '0;
                            st     <= after_ack;
                            if (after_ack == ST_TX) begin
                                txsh <= load_byte;
                                oe   <= ~load_byte[7];
                                if (send_cnt) send_cnt <= 1'b0;
                                else          ptr <= ptr + 1'b1;
                            end else begin
                                oe <= 1'b0;
                            end
                        end
                    end else if (ev.scl_rise && bitcnt < 4'd8) begin
                        sh     <= {sh[6:0], ev.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        acking <= 1'b1;
                        oe     <= 1'b1;
                        case (st)
                            ST_ADDR: begin
                                if (sh[7:1] != DEV_ADDR) begin
                                    acking <= 1'b0;
                                    oe     <= 1'b0;
                                    st     <= ST_IDLE;
                                end else if (sh[0]) begin
                                    after_ack <= ST_TX;
                                    send_cnt  <= blk;
                                    if (blk) ptr <= '0;
                                end else begin
                                    after_ack <= ST_CMD;
                                end
                            end
                            ST_CMD: begin
                                if (!cmd_select_ok(sh)) begin
                                    acking <= 1'b0;
                                    oe     <= 1'b0;
                                    st     <= ST_IDLE;
                                end else begin
                                    blk       <= ~cmd_indexed(sh);
                                    ptr       <= cmd_indexed(sh) ? sh[OFFS_W-1:0] : '0;
                                    after_ack <= cmd_indexed(sh) ? ST_WDATA : ST_COUNT;
                                end
                            end
                            ST_COUNT: after_ack <= ST_WDATA;
                            default: begin
                                after_ack <= ST_WDATA;
                                ptr       <= ptr + 1'b1;
                            end
                        endcase
                    end
                end
                ST_TX: begin
                    if (ev.scl_rise && bitcnt < 4'd8) begin
                        bitcnt <= bitcnt + 1'b1;
                    end else if (ev.scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            oe <= 1'b0;
                            st <= ST_MACK;
                        end else begin
                            oe   <= ~txsh[6];
                            txsh <= {txsh[6:0], 1'b0};
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.scl_rise) begin
                        mack_ok <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (mack_ok) begin
                            txsh   <= load_byte;
                            oe     <= ~load_byte[7];
                            bitcnt <= '0;
                            st     <= ST_TX;
                            if (send_cnt) send_cnt <= 1'b0;
                            else          ptr <= ptr + 1'b1;
                        end else begin
                            oe <= 1'b0;
                            st <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(oe) |-> !$past(ev.scl)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !oe); // R1

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (st == ST_IDLE && !oe)); // R10

endmodule

// File: rtl/smbreg_slave.sv
module smbreg_slave
    import smbreg_pkg::*;
#(
    parameter int NREG        = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       core_we,
    input  logic [4:0] core_waddr,
    input  logic [7:0] core_wdata,
    input  logic [4:0] core_raddr,
    output logic [7:0] core_rdata
);
    busev_t            ev;
    logic              bus_we;
    logic [OFFS_W-1:0] bus_addr;
    logic [7:0]        bus_wdata;
    logic [7:0]        bus_rdata;

    smbreg_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    smbreg_link_fsm #(.NREG(NREG)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .sda_oe    (sda_oe),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    smbreg_bank #(.NREG(NREG)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .core_we    (core_we),
        .core_waddr (core_waddr),
        .core_wdata (core_wdata),
        .core_raddr (core_raddr),
        .core_rdata (core_rdata)
    );

endmodule

// File: tb/sim_smbreg_slave.sv
module sim_smbreg_slave;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic       core_we = 1'b0;
    logic [4:0] core_waddr = '0;
    logic [7:0] core_wdata = '0;
    logic [4:0] core_raddr = '0;
    logic [7:0] core_rdata;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    smbreg_slave u0 (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .core_we(core_we), .core_waddr(core_waddr), .core_wdata(core_wdata),
        .core_raddr(core_raddr), .core_rdata(core_rdata)
    );

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start;
        m_sda = 1'b0; hw(H);
        scl = 1'b0; hw(2);
    endtask

    task automatic bus_restart;
        m_sda = 1'b1; hw(H);
        scl = 1'b1; hw(H);
        m_sda = 1'b0; hw(H);
        scl = 1'b0; hw(2);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; hw(H);
        scl = 1'b1; hw(H);
        m_sda = 1'b1; hw(H);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; hw(H);
        scl = 1'b1; hw(H);
        scl = 1'b0; hw(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; hw(H);
        scl = 1'b1; hw(H/2);
        ack = ~sda_line;
        hw(H/2);
        scl = 1'b0; hw(2);
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] d);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hw(H);
            scl = 1'b1; hw(H/2);
            d[i] = sda_line;
            hw(H/2);
            scl = 1'b0; hw(2);
        end
        m_sda = m_ack ? 1'b0 : 1'b1; hw(H);
        scl = 1'b1; hw(H);
        scl = 1'b0; hw(2);
        m_sda = 1'b1;
    endtask

    task automatic core_read(input logic [4:0] a, output logic [7:0] d);
        core_raddr = a; hw(1);
        d = core_rdata;
    endtask

    task automatic byte_write(input logic [4:0] off, input logic [7:0] d, output logic [2:0] acks);
        bus_start;
        send_byte(8'hD2, acks[2]);
        send_byte({3'b100, off}, acks[1]);
        send_byte(d, acks[0]);
        bus_stop;
    endtask

    task automatic byte_read(input logic [4:0] off, output logic [7:0] d, output logic [2:0] acks);
        bus_start;
        send_byte(8'hD2, acks[2]);
        send_byte({3'b100, off}, acks[1]);
        bus_restart;
        send_byte(8'hD3, acks[0]);
        recv_byte(1'b0, d);
        bus_stop;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R2 sda released after reset", sda_oe, 1'b0);
        core_read(5'd0, d);  chk("R9 reg0 default", d, 8'h87);
        core_read(5'd3, d);  chk("R9 reg3 default", d, 8'h63);
        core_read(5'd7, d);  chk("R9 reg7 default", d, 8'h88);
        core_read(5'd11, d); chk("R9 reg11 default", d, 8'h21);
        core_read(5'd2, d);  chk("R9 reg2 default", d, 8'h00);
    endtask

    task automatic t_byte_write;
        logic [2:0] acks;
        logic [7:0] d;
        byte_write(5'd6, 8'hA5, acks);
        chk("R1 R4 byte write acks", acks, 3'b111);
        core_read(5'd6, d);
        chk("R4 byte write stored", d, 8'hA5);
        core_read(5'd5, d);
        chk("R3 neighbour untouched", d, 8'hFF);
        chk("R2 sda released after stop", sda_oe, 1'b0);
    endtask

    task automatic t_byte_read;
        logic [2:0] acks;
        logic [7:0] d;
        byte_read(5'd3, d, acks);
        chk("R5 byte read acks", acks, 3'b111);
        chk("R5 byte read data", d, 8'h63);
        byte_read(5'd6, d, acks);
        chk("R5 byte read written reg", d, 8'hA5);
    endtask

    task automatic t_bad_address;
        logic a0, a1, a2;
        logic [7:0] d;
        bus_start;
        send_byte(8'hA0, a0);
        send_byte(8'h84, a1);
        send_byte(8'h00, a2);
        bus_stop;
        chk("R1 foreign address not acked", {a0, a1, a2}, 3'b000);
        core_read(5'd4, d);
        chk("R1 foreign address wrote nothing", d, 8'hFF);
    endtask

    task automatic t_bad_select;
        logic a0, a1, a2;
        logic [7:0] d;
        bus_start;
        send_byte(8'hD2, a0);
        send_byte(8'hE4, a1);
        send_byte(8'h00, a2);
        bus_stop;
        chk("R3 bad select acks", {a0, a1, a2}, 3'b100);
        core_read(5'd4, d);
        chk("R3 bad select wrote nothing", d, 8'hFF);
    endtask

    task automatic t_block_write;
        logic [5:0] a;
        logic [7:0] d;
        bus_start;
        send_byte(8'hD2, a[5]);
        send_byte(8'h00, a[4]);
        send_byte(8'h05, a[3]);
        send_byte(8'h11, a[2]);
        send_byte(8'h22, a[1]);
        send_byte(8'h33, a[0]);
        bus_stop;
        chk("R6 block write acks", a, 6'b111111);
        core_read(5'd0, d); chk("R6 block reg0", d, 8'h11);
        core_read(5'd1, d); chk("R6 block reg1", d, 8'h22);
        core_read(5'd2, d); chk("R6 block reg2", d, 8'h33);
        core_read(5'd3, d); chk("R6 early stop keeps reg3", d, 8'h63);
    endtask

    task automatic t_block_read;
        logic a0, a1, a2;
        logic [7:0] c, d0, d1, d2;
        bus_start;
        send_byte(8'hD2, a0);
        send_byte(8'h00, a1);
        bus_restart;
        send_byte(8'hD3, a2);
        recv_byte(1'b1, c);
        recv_byte(1'b1, d0);
        recv_byte(1'b1, d1);
        recv_byte(1'b0, d2);
        bus_stop;
        chk("R7 block read acks", {a0, a1, a2}, 3'b111);
        chk("R7 leading count", c, 8'd12);
        chk("R7 block data0", d0, 8'h11);
        chk("R7 block data1", d1, 8'h22);
        chk("R7 block data2", d2, 8'h33);
    endtask

    task automatic t_out_of_range;
        logic [2:0] acks;
        logic [7:0] d;
        byte_write(5'd20, 8'h77, acks);
        chk("R8 high offset write acked", acks, 3'b111);
        byte_read(5'd20, d, acks);
        chk("R8 high offset bus read zero", d, 8'h00);
        core_read(5'd20, d);
        chk("R8 high offset core read zero", d, 8'h00);
    endtask

    task automatic t_abort;
        logic a0, a1;
        logic [2:0] acks;
        logic [7:0] d;
        bus_start;
        send_byte(8'hD2, a0);
        send_byte(8'h84, a1);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop;
        chk("R10 released after abort", sda_oe, 1'b0);
        core_read(5'd4, d);
        chk("R10 partial byte not written", d, 8'hFF);
        byte_read(5'd4, d, acks);
        chk("R10 bus usable after abort", {acks, d}, {3'b111, 8'hFF});
    endtask

    task automatic t_core_port;
        logic [2:0] acks;
        logic [7:0] d;
        core_waddr = 5'd9; core_wdata = 8'h5A; core_we = 1'b1; hw(1);
        core_we = 1'b0; hw(1);
        core_read(5'd9, d);
        chk("R11 core write readback", d, 8'h5A);
        byte_read(5'd9, d, acks);
        chk("R11 core write seen on bus", d, 8'h5A);
    endtask

    initial begin
        hw(5);
        rst = 1'b0;
        hw(4);
        t_reset;
        t_byte_write;
        t_byte_read;
        t_bad_address;
        t_bad_select;
        t_block_write;
        t_block_read;
        t_out_of_range;
        t_abort;
        t_core_port;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule